// File: doc/BRIEF.md
# Acquisition and Sleep Sequencer

This block decides when a touch-sensing front end measures, sleeps and lets the host talk. It watches the active-low select line from the host, a transfer-in-progress flag and a per-edge serial-clock activity strobe from the serial slave. From these it drives a ready handshake toward the host and starts an abstract measurement burst. The burst is modelled as a fixed busy interval of `BURST_T` clock ticks. Every duration is a parameter counted in system clock ticks, so a test build can shrink them.

After reset the ready line is released (output enable low) and then driven low while the front end calibrates. Once calibration is done the line is driven high. The host decodes the ready line as follows: low means it must stay off the bus, and high means results can be read. With select held high, bursts repeat on their own. A select-low frame that carries clocking puts the block to sleep once the transfer ends, and the block wakes when select rises or when a long timer runs out. A select-low pulse without clocking is classified by its width: a short pulse is ignored, a pulse of middle width triggers a burst after a discharge hold, and a long pulse puts the block to sleep. Clocking that runs on too long sends the block back to its power-up sequence.

There is no data stream here, so no port uses a valid/ready pair. All pins are plain control and status levels or one-cycle strobes.

Top module: `acq_seq`

## Requirements
- R1: After reset `rdy_oe` is 0 for exactly `FLOAT_T` cycles. Then `rdy_oe`=1 and `rdy_out`=0 for exactly `CAL_T` cycles. Then `rdy_out`=1. No burst is active while `rdy_oe`=0.
- R2: While the block is ready, `rdy_out` stays 1. This holds with select high and through a select-low frame until that frame is classified.
- R3: With select held high and no transfer, the first cycles of successive bursts are exactly `FREERUN_T + BURST_T` cycles apart.
- R4: A burst keeps `burst_active`=1 for exactly `BURST_T` cycles, and `burst_start` is 1 in its first cycle. `rdy_out` is 0 throughout the burst and returns to 1 in the cycle after it.
- R5: If clocking is seen during a select-low frame (`sck_edge` or `xfer_active`), the block sleeps (`sleeping`=1, `rdy_out`=0) from the cycle after `xfer_active` falls. It starts no burst while select stays low, until the auto-wake timer runs out.
- R6: When select rises during sleep, the block waits `WAKE_T` cycles with `rdy_out`=0, and the burst then starts.
- R7: If select stays low, sleep ends after `AUTOWAKE_T` cycles, and a burst starts `WAKE_T` cycles after that.
- R8: A select-low pulse without clocking, where the count of low cycles minus one lies between `DMIN_T` and `DMAX_T`, is a dummy trigger. After select rises, `rdy_out` stays 1 for exactly `DISCH_T` cycles and the burst then starts.
- R9: A select-low pulse without clocking that is shorter than the dummy minimum has no effect: `rdy_out` stays 1, no burst starts and `sleeping` stays 0.
- R10: A select-low pulse without clocking that stays low longer than `DMAX_T` puts the block to sleep (`sleeping`=1, `rdy_out`=0) while select is still low.
- R11: When `xfer_active` is 1 for `CLKWD_T` consecutive cycles, `rdy_oe` drops to 0 in the next cycle and the whole R1 sequence starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Host select, active low |
| xfer_active | input | 1 | Serial slave reports a transfer in progress |
| sck_edge | input | 1 | One-cycle strobe for each serial clock edge seen |
| rdy_out | output | 1 | Ready level toward the host (1 = host may talk) |
| rdy_oe | output | 1 | Output enable of the ready pin (0 = released) |
| burst_start | output | 1 | One-cycle strobe in the first cycle of a burst |
| burst_active | output | 1 | Measurement burst busy interval |
| sleeping | output | 1 | Block is in its low-power sleep state |

## Verification
Some rules are checked by the assertions on every cycle:
- the ready line is low whenever a burst is busy;
- a burst never runs longer than its length and never ends early unless it is aborted;
- no burst occurs while the ready pin is released;
- the ready pin is released only after transfer activity, and always once the clocking watchdog limit is reached.

Other behaviour depends on the history of the select line, so only the directed scenarios can show it:
- how pulses are classified by width;
- the discharge hold before a dummy-triggered burst;
- the wake delay and the auto-wake timer;
- the free-running period;
- the replay of calibration after a watchdog reset.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_FLOAT,
    ST_CAL,
    ST_IDLE,
    ST_SELLOW,
    ST_DHOLD,
    ST_SLEEP,
    ST_WAKE,
    ST_BURST
  } seq_state_t;

  typedef enum logic [2:0] {
    CLS_STAY,
    CLS_IGNORE,
    CLS_DUMMY,
    CLS_SLEEP,
    CLS_WAKE
  } sel_cls_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_upcnt.sv
module seq_upcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q <= '0;
    else if (clr)            q <= '0;
    else if (en && q != TOP) q <= q + 1'b1;
  end
endmodule

// File: rtl/seq_wdog.sv
module seq_wdog #(
  parameter int unsigned LIMIT_T = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic trip
);
  localparam int unsigned WW = $clog2(LIMIT_T + 1);
  logic [WW-1:0] run;

  assign trip = active && (run == WW'(LIMIT_T - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run <= '0;
    else if (!active || trip)  run <= '0;
    else                       run <= run + 1'b1;
  end
endmodule

// File: rtl/seq_pulse_class.sv
module seq_pulse_class
  import seq_pkg::*;
#(
  parameter int unsigned DMIN_T = 10,
  parameter int unsigned DMAX_T = 10000,
  parameter int unsigned CW     = 16
) (
  input  logic          sel_n,
  input  logic [CW-1:0] low_cnt,
  input  logic          seen,
  input  logic          xfer_active,
  output sel_cls_t      cls
);
  always_comb begin
    cls = CLS_STAY;
    if (sel_n) begin
      if (seen)                          cls = CLS_WAKE;
      else if (low_cnt >= CW'(DMIN_T))   cls = CLS_DUMMY;
      else                               cls = CLS_IGNORE;
    end else begin
      if (seen && !xfer_active)          cls = CLS_SLEEP;
      else if (!seen && low_cnt >= CW'(DMAX_T)) cls = CLS_SLEEP;
    end
  end
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import seq_pkg::*;
#(
  parameter int unsigned FLOAT_T    = 20000,
  parameter int unsigned CAL_T      = 525000,
  parameter int unsigned FREERUN_T  = 58000,
  parameter int unsigned BURST_T    = 400,
  parameter int unsigned WAKE_T     = 920,
  parameter int unsigned DMIN_T     = 10,
  parameter int unsigned DMAX_T     = 10000,
  parameter int unsigned DISCH_T    = 700,
  parameter int unsigned AUTOWAKE_T = 3000000,
  parameter int unsigned CLKWD_T    = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic xfer_active,
  input  logic sck_edge,
  output logic rdy_out,
  output logic rdy_oe,
  output logic burst_start,
  output logic burst_active,
  output logic sleeping
);
  localparam int unsigned PH_MAX = max_u(max_u(max_u(FLOAT_T, CAL_T), max_u(BURST_T, WAKE_T)),
                                         max_u(max_u(DMAX_T, DISCH_T), AUTOWAKE_T));
  localparam int unsigned CW = $clog2(PH_MAX + 2);
  localparam int unsigned FW = $clog2(FREERUN_T + 1);

  seq_state_t    state, nstate;
  logic [CW-1:0] ph_cnt;
  logic [FW-1:0] fr_cnt;
  logic          wd_trip;
  logic          sck_seen;
  logic          seen_now;
  sel_cls_t      cls;

  // phase timer: restarts on every state change or watchdog trip
  seq_upcnt #(.W(CW)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .clr((state != nstate) || wd_trip),
    .en(1'b1),
    .q(ph_cnt)
  );

  // free-running interval: counts ready time with select high
  seq_upcnt #(.W(FW)) u_free (
    .clk(clk), .rst_n(rst_n),
    .clr((state == ST_BURST) || (state == ST_FLOAT) || wd_trip),
    .en((state == ST_IDLE) && sel_n),
    .q(fr_cnt)
  );

  seq_wdog #(.LIMIT_T(CLKWD_T)) u_wdog (
    .clk(clk), .rst_n(rst_n),
    .active(xfer_active),
    .trip(wd_trip)
  );

  assign seen_now = sck_seen || sck_edge || xfer_active;

  seq_pulse_class #(.DMIN_T(DMIN_T), .DMAX_T(DMAX_T), .CW(CW)) u_cls (
    .sel_n(sel_n),
    .low_cnt(ph_cnt),
    .seen(seen_now),
    .xfer_active(xfer_active),
    .cls(cls)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sck_seen <= 1'b0;
    else if (state != ST_SELLOW) sck_seen <= 1'b0;
    else if (seen_now)           sck_seen <= 1'b1;
  end

  always_comb begin
    nstate = state;
    unique case (state)
      ST_FLOAT:  if (ph_cnt == CW'(FLOAT_T - 1)) nstate = ST_CAL;
      ST_CAL:    if (ph_cnt == CW'(CAL_T - 1))   nstate = ST_IDLE;
      ST_IDLE: begin
        if (!sel_n)                              nstate = ST_SELLOW;
        else if (fr_cnt == FW'(FREERUN_T - 1))   nstate = ST_BURST;
      end
      ST_SELLOW: begin
        unique case (cls)
          CLS_IGNORE: nstate = ST_IDLE;
          CLS_DUMMY:  nstate = ST_DHOLD;
          CLS_SLEEP:  nstate = ST_SLEEP;
          CLS_WAKE:   nstate = ST_WAKE;
          default:    nstate = ST_SELLOW;
        endcase
      end
      ST_DHOLD:  if (ph_cnt == CW'(DISCH_T - 1)) nstate = ST_BURST;
      ST_SLEEP: begin
        if (sel_n)                               nstate = ST_WAKE;
        else if (ph_cnt == CW'(AUTOWAKE_T - 1))  nstate = ST_WAKE;
      end
      ST_WAKE:   if (ph_cnt == CW'(WAKE_T - 1))  nstate = ST_BURST;
      ST_BURST:  if (ph_cnt == CW'(BURST_T - 1)) nstate = ST_IDLE;
      default:                                   nstate = ST_FLOAT;
    endcase
    if (wd_trip) nstate = ST_FLOAT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FLOAT;
    else        state <= nstate;
  end

  assign rdy_oe       = (state != ST_FLOAT);
  assign rdy_out      = (state == ST_IDLE) || (state == ST_SELLOW) || (state == ST_DHOLD);
  assign burst_active = (state == ST_BURST);
  assign burst_start  = (state == ST_BURST) && (ph_cnt == '0);
  assign sleeping     = (state == ST_SLEEP);
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk #(
  parameter int unsigned BURST_T = 400,
  parameter int unsigned CLKWD_T = 15000
) (
  input logic clk,
  input logic rst_n,
  input logic xfer_active,
  input logic rdy_out,
  input logic rdy_oe,
  input logic burst_active
);
  localparam int unsigned BW = $clog2(BURST_T + 2);
  localparam int unsigned RW = $clog2(CLKWD_T + 2);

  logic [BW-1:0] blen;
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            blen <= '0;
    else if (burst_active) blen <= blen + 1'b1;
    else                   blen <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run <= '0;
    else if (!xfer_active)        run <= '0;
    else if (run <= RW'(CLKWD_T)) run <= run + 1'b1;
  end

  p_burst_rdy_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active |-> (rdy_oe && !rdy_out));

  p_burst_len_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active |-> (blen < BW'(BURST_T)));

  p_burst_len_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(burst_active) && rdy_oe) |-> (blen == BW'(BURST_T)));

  p_float_no_burst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_oe |-> !burst_active);

  p_wdog_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run == RW'(CLKWD_T)) |-> !rdy_oe);

  p_release_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_oe) |-> $past(xfer_active));
endmodule

bind acq_seq acq_seq_chk #(.BURST_T(BURST_T), .CLKWD_T(CLKWD_T)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active),
  .rdy_out(rdy_out), .rdy_oe(rdy_oe), .burst_active(burst_active)
);

// File: tb/sim_acq_seq.sv
`timescale 1ns/1ps
module sim_acq_seq;
  localparam int FLOAT_T = 20, CAL_T = 50, FREERUN_T = 200, BURST_T = 30, WAKE_T = 40;
  localparam int DMIN_T = 10, DMAX_T = 100, DISCH_T = 25, AUTOWAKE_T = 500, CLKWD_T = 300;

  logic clk = 0, rst_n = 0, sel_n = 1, xfer_active = 0, sck_edge = 0;
  logic rdy_out, rdy_oe, burst_start, burst_active, sleeping;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  acq_seq #(.FLOAT_T(FLOAT_T), .CAL_T(CAL_T), .FREERUN_T(FREERUN_T), .BURST_T(BURST_T),
            .WAKE_T(WAKE_T), .DMIN_T(DMIN_T), .DMAX_T(DMAX_T), .DISCH_T(DISCH_T),
            .AUTOWAKE_T(AUTOWAKE_T), .CLKWD_T(CLKWD_T)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .xfer_active(xfer_active), .sck_edge(sck_edge),
    .rdy_out(rdy_out), .rdy_oe(rdy_oe), .burst_start(burst_start),
    .burst_active(burst_active), .sleeping(sleeping));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // wait for a burst start, then let the burst finish (block ready, interval restarted)
  task automatic sync_idle();
    int n = 0;
    while (!burst_start && n < 2000) begin tick(1); n++; end
    chk("R3", "burst seen before sync", burst_start, 1);
    tick(BURST_T);
  endtask

  task automatic t_powerup();
    chk("R1", "oe in reset", rdy_oe, 0);
    rst_n = 1;
    tick(FLOAT_T - 1);
    chk("R1", "oe end of float", rdy_oe, 0);
    chk("R1", "no burst in float", burst_active, 0);
    tick(1);
    chk("R1", "oe at cal", rdy_oe, 1);
    chk("R1", "rdy low at cal", rdy_out, 0);
    tick(CAL_T - 1);
    chk("R1", "rdy end of cal", rdy_out, 0);
    tick(1);
    chk("R1", "rdy after cal", rdy_out, 1);
  endtask

  task automatic t_freerun();
    int n = 0;
    while (!burst_start && n < 1000) begin tick(1); n++; end
    chk("R4", "burst start strobe", burst_start, 1);
    chk("R4", "rdy low in burst", rdy_out, 0);
    tick(BURST_T - 1);
    chk("R4", "burst still active at end", burst_active, 1);
    chk("R4", "rdy low at burst end", rdy_out, 0);
    tick(1);
    chk("R4", "burst over", burst_active, 0);
    chk("R4", "rdy after burst", rdy_out, 1);
    n = 0;
    while (!burst_start && n < 1000) begin tick(1); n++; end
    chk("R3", "free-run period", BURST_T + n, FREERUN_T + BURST_T);
    tick(BURST_T);
  endtask

  task automatic t_short();
    int bad_rdy = 0, bursts = 0, slp = 0;
    sel_n = 0; tick(3); sel_n = 1;
    for (int i = 0; i < 40; i++) begin
      tick(1);
      if (!rdy_out) bad_rdy++;
      if (burst_active) bursts++;
      if (sleeping) slp++;
    end
    chk("R9", "rdy drops after short pulse", bad_rdy, 0);
    chk("R9", "burst after short pulse", bursts, 0);
    chk("R9", "sleep after short pulse", slp, 0);
  endtask

  task automatic t_dummy();
    int bad = 0;
    sync_idle();
    sel_n = 0;
    for (int i = 0; i < 30; i++) begin tick(1); if (!rdy_out) bad++; end
    chk("R2", "rdy during select frame", bad, 0);
    sel_n = 1;
    tick(1);
    chk("R8", "rdy at hold start", rdy_out, 1);
    tick(DISCH_T - 1);
    chk("R8", "rdy at hold end", rdy_out, 1);
    chk("R8", "no burst in hold", burst_active, 0);
    tick(1);
    chk("R8", "burst after hold", burst_start, 1);
    tick(BURST_T);
  endtask

  task automatic t_long();
    sync_idle();
    sel_n = 0;
    tick(DMAX_T + 5);
    chk("R10", "sleep on long pulse", sleeping, 1);
    chk("R10", "rdy low on long pulse", rdy_out, 0);
    sel_n = 1;
    tick(1);
    chk("R6", "left sleep", sleeping, 0);
    tick(WAKE_T - 1);
    chk("R6", "no burst before wake delay", burst_active, 0);
    chk("R6", "rdy low in wake", rdy_out, 0);
    tick(1);
    chk("R6", "burst after wake delay", burst_start, 1);
    tick(BURST_T);
  endtask

  task automatic t_xfer_autowake();
    sync_idle();
    sel_n = 0; tick(2);
    xfer_active = 1;
    for (int i = 0; i < 4; i++) begin sck_edge = 1; tick(1); sck_edge = 0; tick(1); end
    xfer_active = 0;
    tick(2);
    chk("R5", "sleep after transfer", sleeping, 1);
    chk("R5", "rdy low in sleep", rdy_out, 0);
    tick(AUTOWAKE_T - 10);
    chk("R5", "still asleep with select low", sleeping, 1);
    tick(WAKE_T + 8);
    chk("R7", "no burst before auto wake", burst_active, 0);
    tick(1);
    chk("R7", "burst after auto wake", burst_start, 1);
    sel_n = 1;
    sync_idle();
  endtask

  task automatic t_wdog();
    sync_idle();
    sel_n = 0; xfer_active = 1;
    tick(CLKWD_T - 1);
    chk("R11", "oe before limit", rdy_oe, 1);
    tick(1);
    chk("R11", "oe released at limit", rdy_oe, 0);
    xfer_active = 0; sel_n = 1;
    tick(FLOAT_T - 1);
    chk("R11", "still released", rdy_oe, 0);
    tick(1);
    chk("R11", "recalibrating", rdy_oe, 1);
    chk("R11", "rdy low recal", rdy_out, 0);
    tick(CAL_T);
    chk("R11", "ready after recal", rdy_out, 1);
  endtask

  initial begin
    tick(3);
    t_powerup();
    t_short();
    t_freerun();
    t_dummy();
    t_long();
    t_xfer_autowake();
    t_wdog();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    tick(1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule